// File: doc/BRIEF.md
# Configurable Pin Cell Group

This block is a bank of sixteen pin-facing cells that sits between the core logic and the device pads. A static configuration word per cell selects how that cell behaves. It can pass the pad value straight to the core. It can capture the pad on an I/O clock edge. It can hold the pad through a level-sensitive latch. It can drive the pad as an output only. It can act as a bidirectional pin whose driver is three-stated by a selectable enable.

The group shares one product-term enable. Each cell picks its own driver enable from four sources: always on, the product-term enable, or either of two global enables. A test enable overrides every functional enable and floats all drivers. Each cell also picks one of two dedicated I/O clocks for its input register or latch.

Both I/O clocks are sampled in the system clock domain, so every capture is a system-clock register gated by the selected I/O clock. The configuration sits in a register bank loaded one cell at a time through a write port.

Top module: `pio_group`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into the cell named by `cfg_idx`, and the new setting takes effect after that clock edge. The layout is [5:3] mode, [2:1] enable select, [0] clock select.
- R2: Mode 0 (direct input) returns `pin_in` to `core_in` in the same cycle.
- R3: Mode 1 (registered input) captures the pad at the first system edge where the selected I/O clock is seen high after having been low. It holds that value at every other edge, including while the clock stays high.
- R4: Mode 2 (latched input) is transparent to the pad while the selected I/O clock is high. While that clock is low it holds the pad value from the last edge at which the clock was high.
- R5: In every input-only mode (0, 1, 2 and the unused codes) `pin_oe` stays low whatever the enable select.
- R6: Mode 3 (output only) drives `pin_oe` with the selected enable and returns 0 on `core_in`. `pin_out` always equals `core_out` for every cell.
- R7: Mode 4 (bidirectional) drives `pin_oe` with the selected enable and returns `pin_in` on `core_in`.
- R8: Enable select 0 means always on, 1 selects `pt_oe`, 2 selects `goe[0]` and 3 selects `goe[1]`.
- R9: While `test_oe` is high, every `pin_oe` bit is 0.
- R10: Clock select 0 uses `io_clk[0]` and clock select 1 uses `io_clk[1]` for both capture modes.
- R11: A synchronous reset clears every captured value to 0 and every configuration word to 0, which is direct input with the enable set to always on. Mode codes 5 to 7 behave as direct input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Cell index for the write |
| cfg_wdata | input | 6 | Configuration word |
| core_out | input | 16 | Core data toward the pads |
| pt_oe | input | 1 | Shared product-term enable |
| goe | input | 2 | Global enables |
| test_oe | input | 1 | Test override, floats all drivers |
| io_clk | input | 2 | Dedicated I/O clocks |
| pin_in | input | 16 | Pad receive data |
| pin_out | output | 16 | Pad drive data |
| pin_oe | output | 16 | Pad driver enables |
| core_in | output | 16 | Pad data returned to the core |

## Verification
The bench holds the I/O clock high across several edges and changes the pad in between. A registered cell that captured on the clock level instead of its rise would follow the pad when it should hold. It then drops the clock right after a transparent phase. A latch that failed to hold would show the new pad value instead of the last value seen while the clock was high. The bench walks the enable sources one by one and asserts the test override. A swapped select or an override that missed a cell would leave a stray bit in `pin_oe`. Finally it resets with a bidirectional cell and an always-on input cell present. A reset that left configuration or captures behind would keep a driver on or return a stale bit.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam logic [2:0] MODE_DIRECT = 3'd0;
    localparam logic [2:0] MODE_REG    = 3'd1;
    localparam logic [2:0] MODE_LATCH  = 3'd2;
    localparam logic [2:0] MODE_OUT    = 3'd3;
    localparam logic [2:0] MODE_BIDIR  = 3'd4;

    localparam logic [1:0] EN_ALWAYS = 2'd0;
    localparam logic [1:0] EN_PTERM  = 2'd1;
    localparam logic [1:0] EN_GLOB0  = 2'd2;
    localparam logic [1:0] EN_GLOB1  = 2'd3;

    typedef struct packed {
        logic [2:0] mode;
        logic [1:0] en_sel;
        logic       clk_sel;
    } pio_cfg_t;

    typedef struct packed {
        logic cap;
    } pio_cell_st_t;

endpackage

// File: rtl/pio_cfg_store.sv
module pio_cfg_store
    import pio_pkg::*;
#(
    parameter int NCELL = 16,
    localparam int IDX_W = $clog2(NCELL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  pio_cfg_t         wdata,
    output pio_cfg_t         cfg_o [NCELL]
);

    pio_cfg_t cfg_d [NCELL];
    pio_cfg_t cfg_q [NCELL];

    always_comb begin
        for (int i = 0; i < NCELL; i++) begin
            cfg_d[i] = cfg_q[i];
            if (we && (int'(idx) == i)) begin
                cfg_d[i] = wdata;
            end
            if (rst) begin
                cfg_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    for (genvar g = 0; g < NCELL; g++) begin : g_chk
        assert_cfg_write_R1: assert property (@(posedge clk) disable iff (rst)
            (we && (int'(idx) == g)) |=> (cfg_q[g] == $past(wdata)));
    end

endmodule

// File: rtl/pio_clk_sample.sv
module pio_clk_sample #(
    parameter int NCLK = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCLK-1:0] io_clk,
    output logic [NCLK-1:0] lvl,
    output logic [NCLK-1:0] rise
);

    logic [NCLK-1:0] prev_d;
    logic [NCLK-1:0] prev_q;

    always_comb begin
        prev_d = io_clk;
        if (rst) begin
            prev_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    assign lvl  = io_clk;
    assign rise = io_clk & ~prev_q;

    for (genvar g = 0; g < NCLK; g++) begin : g_chk
        assert_single_rise_R3: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]);
    end

endmodule

// File: rtl/pio_cell.sv
module pio_cell
    import pio_pkg::*;
#(
    parameter int NCLK = 2,
    parameter int NGOE = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  pio_cfg_t        cfg,
    input  logic [NCLK-1:0] clk_lvl,
    input  logic [NCLK-1:0] clk_rise,
    input  logic            pt_oe,
    input  logic [NGOE-1:0] goe,
    input  logic            test_oe,
    input  logic            core_out,
    input  logic            pin_in,
    output logic            pin_out,
    output logic            pin_oe,
    output logic            core_in
);

    pio_cell_st_t st_d;
    pio_cell_st_t st_q;
    logic         sel_lvl;
    logic         sel_rise;
    logic         en_pick;
    logic         drives;

    always_comb begin
        sel_lvl  = clk_lvl[cfg.clk_sel];
        sel_rise = clk_rise[cfg.clk_sel];

        unique case (cfg.en_sel)
            EN_ALWAYS: en_pick = 1'b1;
            EN_PTERM:  en_pick = pt_oe;
            EN_GLOB0:  en_pick = goe[0];
            default:   en_pick = goe[1];
        endcase

        drives = (cfg.mode == MODE_OUT) || (cfg.mode == MODE_BIDIR);

        st_d = st_q;
        if ((cfg.mode == MODE_REG) && sel_rise) begin
            st_d.cap = pin_in;
        end else if ((cfg.mode == MODE_LATCH) && sel_lvl) begin
            st_d.cap = pin_in;
        end
        if (rst) begin
            st_d = '0;
        end

        case (cfg.mode)
            MODE_REG:   core_in = st_q.cap;
            MODE_LATCH: core_in = sel_lvl ? pin_in : st_q.cap;
            MODE_OUT:   core_in = 1'b0;
            default:    core_in = pin_in;
        endcase

        pin_out = core_out;
        pin_oe  = drives && en_pick && !test_oe;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assert_reg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode == MODE_REG) && !sel_rise) |=> $stable(st_q.cap));
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode == MODE_LATCH) && !sel_lvl) |=> $stable(st_q.cap));
    assert_input_hiz_R5: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode != MODE_OUT) && (cfg.mode != MODE_BIDIR)) |-> !pin_oe);
    assert_out_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_OUT) |-> !core_in);
    assert_bidir_loop_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_BIDIR) |-> (core_in == pin_in));

endmodule

// File: rtl/pio_group.sv
module pio_group
    import pio_pkg::*;
#(
    parameter int NCELL = 16,
    localparam int IDX_W = $clog2(NCELL),
    localparam int CFG_W = $bits(pio_cfg_t)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [NCELL-1:0] core_out,
    input  logic             pt_oe,
    input  logic [1:0]       goe,
    input  logic             test_oe,
    input  logic [1:0]       io_clk,
    input  logic [NCELL-1:0] pin_in,
    output logic [NCELL-1:0] pin_out,
    output logic [NCELL-1:0] pin_oe,
    output logic [NCELL-1:0] core_in
);

    pio_cfg_t   cfg [NCELL];
    logic [1:0] clk_lvl;
    logic [1:0] clk_rise;

    pio_cfg_store #(.NCELL(NCELL)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (pio_cfg_t'(cfg_wdata)),
        .cfg_o (cfg)
    );

    pio_clk_sample #(.NCLK(2)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .io_clk (io_clk),
        .lvl    (clk_lvl),
        .rise   (clk_rise)
    );

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        pio_cell #(.NCLK(2), .NGOE(2)) u_cell (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg[g]),
            .clk_lvl  (clk_lvl),
            .clk_rise (clk_rise),
            .pt_oe    (pt_oe),
            .goe      (goe),
            .test_oe  (test_oe),
            .core_out (core_out[g]),
            .pin_in   (pin_in[g]),
            .pin_out  (pin_out[g]),
            .pin_oe   (pin_oe[g]),
            .core_in  (core_in[g])
        );
    end

    assert_test_float_R9: assert property (@(posedge clk) disable iff (rst)
        test_oe |-> (pin_oe == '0));

endmodule

// File: tb/sim_pio_group.sv
module sim_pio_group;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [5:0]  cfg_wdata;
    logic [15:0] core_out;
    logic        pt_oe;
    logic [1:0]  goe;
    logic        test_oe;
    logic [1:0]  io_clk;
    logic [15:0] pin_in;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [15:0] core_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] ein;
        logic [15:0] mask;
        logic [15:0] eoe;
        logic [15:0] eout;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    pio_group u0 (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .core_out  (core_out),
        .pt_oe     (pt_oe),
        .goe       (goe),
        .test_oe   (test_oe),
        .io_clk    (io_clk),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .core_in   (core_in)
    );

    task automatic push(string tag, logic [15:0] ein, logic [15:0] mask, logic [15:0] eoe);
        exp_t e;
        e.tag = tag; e.ein = ein; e.mask = mask; e.eoe = eoe; e.eout = core_out;
        sb.push_back(e);
    endtask

    task automatic cfg_write(int idx, logic [2:0] mode, logic [1:0] en, logic cs);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = {mode, en, cs};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (((core_in & e.mask) !== (e.ein & e.mask)) || (pin_oe !== e.eoe) ||
                    (pin_out !== e.eout)) begin
                    n_fail++;
                    $display("FAIL %s: core_in=%h oe=%h out=%h expected core_in=%h (mask %h) oe=%h out=%h",
                             e.tag, core_in, pin_oe, pin_out, e.ein, e.mask, e.eoe, e.eout);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        core_out = 16'hFFFF; pt_oe = 1'b0; goe = 2'b00; test_oe = 1'b0;
        io_clk = 2'b00; pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pin_in = 16'hA5A5;
        push("R11 R2 reset state direct input", 16'hA5A5, 16'hFFFF, 16'h0000);

        cfg_write(0, 3'd3, 2'd0, 1'b0);
        cfg_write(1, 3'd3, 2'd1, 1'b0);
        cfg_write(2, 3'd3, 2'd2, 1'b0);
        cfg_write(3, 3'd3, 2'd3, 1'b0);
        cfg_write(4, 3'd4, 2'd1, 1'b0);
        cfg_write(5, 3'd1, 2'd0, 1'b0);
        cfg_write(6, 3'd1, 2'd0, 1'b1);
        cfg_write(7, 3'd2, 2'd0, 1'b0);
        cfg_write(8, 3'd2, 2'd0, 1'b1);
        cfg_write(9, 3'd0, 2'd0, 1'b0);
        cfg_write(10, 3'd6, 2'd0, 1'b0);
        cfg_write(11, 3'd1, 2'd0, 1'b0);
        pin_in = 16'h0000;
        push("R1 R8 R5 config, always-on only", 16'h0000, 16'hFFFF, 16'h0001);

        @(negedge clk); pt_oe = 1'b1;
        push("R8 product-term enable", 16'h0000, 16'hFFFF, 16'h0013);
        @(negedge clk); goe[0] = 1'b1;
        push("R8 global enable 0", 16'h0000, 16'hFFFF, 16'h0017);
        @(negedge clk); goe[1] = 1'b1;
        push("R8 global enable 1", 16'h0000, 16'hFFFF, 16'h001F);
        @(negedge clk); test_oe = 1'b1;
        push("R9 test override floats all", 16'h0000, 16'hFFFF, 16'h0000);
        @(negedge clk); test_oe = 1'b0;
        pin_in = 16'h0411;
        push("R6 R7 R11 out/bidir/unused-code return", 16'h0410, 16'hFFFF, 16'h001F);
        @(negedge clk); core_out = 16'h5A5A;
        push("R6 pin_out follows core_out", 16'h0410, 16'hFFFF, 16'h001F);

        @(negedge clk); pin_in = 16'h01E0;
        push("R3 R4 hold with clocks low", 16'h0000, 16'h01E0, 16'h001F);
        @(negedge clk); io_clk[0] = 1'b1;
        push("R4 latch transparent, R3 not yet captured", 16'h0080, 16'h01E0, 16'h001F);
        @(negedge clk);
        push("R3 capture after rise", 16'h00A0, 16'h01E0, 16'h001F);
        @(negedge clk); pin_in = 16'h0140;
        push("R3 hold while clock stays high", 16'h0020, 16'h01E0, 16'h001F);
        @(negedge clk); pin_in = 16'h01C0;
        push("R4 transparent follows pad", 16'h00A0, 16'h01E0, 16'h001F);
        @(negedge clk); io_clk[0] = 1'b0; pin_in = 16'h0140;
        push("R4 hold after clock falls", 16'h00A0, 16'h01E0, 16'h001F);
        @(negedge clk); io_clk[1] = 1'b1;
        push("R10 second clock latch transparent", 16'h01A0, 16'h01E0, 16'h001F);
        @(negedge clk);
        push("R10 second clock register capture", 16'h01E0, 16'h01E0, 16'h001F);

        @(negedge clk); io_clk = 2'b00; rst = 1'b1;
        @(negedge clk); rst = 1'b0; pin_in = 16'h0160;
        push("R11 reset clears config", 16'h0160, 16'hFFFF, 16'h0000);
        cfg_write(5, 3'd1, 2'd0, 1'b0);
        push("R11 reset clears capture", 16'h0140, 16'hFFFF, 16'h0000);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule